// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block fronts an on-chip scratchpad made of many single-word banks. It takes one access from a group of lanes at a time. Each active lane brings a word address and, for a store, a data word. The block works out which bank each address lands in. In every cycle it lets each bank serve one distinct word. Lanes that name the same word in that bank are served together in that same cycle. Lanes that collide on a bank with a different word wait for later cycles.

When every active lane has been served, the block raises a one-cycle completion pulse. With that pulse it returns the loaded word for each lane and the number of serving cycles the access needed. A caller uses that cycle count to see how well its address pattern suits the banks. For example, padding a row of a two-dimensional array by one word can turn a fully serialized column walk into a single-cycle access. Loads and stores use the same path, chosen by a store flag. The bank storage sits inside the block as register arrays that clear on reset.

Top module: `scp_conflict_serializer`

## Requirements
- R1: Lane l's word address sits in `req_addr[l*ADDR_W +: ADDR_W]` and its store data in `req_wdata[l*DATA_W +: DATA_W]`. Its bank is the address modulo BANKS (the low log2(BANKS) bits) and its row is the remaining upper bits. A word stored at an address is returned by any later load of that address.
- R2: An access whose active lanes all fall in different banks completes in one serving cycle (`rd_cycles` = 1).
- R3: Lanes that hit the same bank with different addresses are served in separate cycles. `rd_cycles` equals the largest number of distinct addresses in any one bank. A lane stride of BANKS words gives BANKS cycles, and a stride of BANKS+1 gives one cycle.
- R4: All lanes that load the same address are served together in one cycle, and each receives that word.
- R5: When several lanes store to the same address in one access, the word from the highest-numbered of them is the one kept.
- R6: A request is taken only when `req_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance until the completion cycle. A request presented while `busy` is high is ignored and changes no stored word.
- R7: `done` is high for exactly one cycle, in the cycle after the last serving cycle, with `busy` low. `rd_data` and `rd_cycles` are valid in that cycle.
- R8: Lanes whose `req_mask` bit is 0 are not served and return zero. A store access returns zero on every lane. An access with an empty mask completes after one busy cycle with `rd_cycles` = 0.
- R9: After reset, `busy`, `done` and `rd_cycles` are 0 and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store access, 0 = load access |
| req_mask | input | LANES | Active lane bits |
| req_addr | input | LANES*ADDR_W | Packed per-lane word addresses |
| req_wdata | input | LANES*DATA_W | Packed per-lane store words |
| busy | output | 1 | Access in progress; new requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | LANES*DATA_W | Packed per-lane loaded words |
| rd_cycles | output | $clog2(LANES+1) | Serving cycles the access used |

## Verification
The bench builds the block with 32 lanes, 32 banks, 32-bit words and 10-bit word addresses. That gives 32 rows per bank, so a stride of 32 words reaches 32 different rows of bank 0 and shows the full 32-cycle worst case. Its stride-33 counterpart then spreads over every bank. Random accesses confined to a 64-word window (two rows per bank) mix broadcasts, two-way conflicts, partial masks and same-address stores. A reference model checks each of these against the busy, done and data timing cycle by cycle.

// File: rtl/scp_pkg.sv
package scp_pkg;
   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_SERVE = 1'b1
   } scp_state_e;
endpackage

// File: rtl/scp_bank_pick.sv
module scp_bank_pick #(
   parameter int LANES   = 32,
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 32,
   parameter int BANK_W  = 5,
   parameter int BANK_ID = 0,
   localparam int ROW_W  = ADDR_W - BANK_W
) (
   input  logic [LANES-1:0]        pend,
   input  logic [LANES*ADDR_W-1:0] addr_flat,
   input  logic [LANES*DATA_W-1:0] wdata_flat,
   output logic                    hit,
   output logic [ROW_W-1:0]        row,
   output logic [LANES-1:0]        take,
   output logic [DATA_W-1:0]       wsel
);
   localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

   logic [ADDR_W-1:0] lead;

   // lowest pending lane on this bank picks the word; equal addresses ride along
   always_comb begin
      hit  = 1'b0;
      lead = '0;
      for (int l = 0; l < LANES; l++) begin
         if (!hit && pend[l] && addr_flat[l*ADDR_W +: BANK_W] == MY_BANK) begin
            hit  = 1'b1;
            lead = addr_flat[l*ADDR_W +: ADDR_W];
         end
      end
      take = '0;
      wsel = '0;
      for (int l = 0; l < LANES; l++) begin
         if (hit && pend[l] && addr_flat[l*ADDR_W +: ADDR_W] == lead) begin
            take[l] = 1'b1;
            wsel    = wdata_flat[l*DATA_W +: DATA_W]; // later lane overrides
         end
      end
   end

   assign row = lead[ADDR_W-1:BANK_W];
endmodule

// File: rtl/scp_bank_ram.sv
module scp_bank_ram #(
   parameter int ROW_W  = 5,
   parameter int DATA_W = 32,
   localparam int ROWS  = 1 << ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      end else if (we) begin
         mem[row] <= wdata;
      end
   end

   assign rdata = mem[row];
endmodule

// File: rtl/scp_conflict_serializer.sv
module scp_conflict_serializer
   import scp_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int BANKS  = 32,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = ADDR_W - BANK_W,
   localparam int CNT_W  = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [LANES-1:0]        req_mask,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES*DATA_W-1:0] req_wdata,
   output logic                    busy,
   output logic                    done,
   output logic [LANES*DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]        rd_cycles
);
   // elaboration-time parameter checks
   if (BANKS < 2 || (1 << BANK_W) != BANKS) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (ADDR_W <= BANK_W) begin : g_bad_addr
      $error("ADDR_W must exceed log2(BANKS)");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   scp_state_e              state;
   logic [LANES-1:0]        pend;
   logic                    wr_q;
   logic [LANES*ADDR_W-1:0] addr_q;
   logic [LANES*DATA_W-1:0] wdata_q;
   logic [LANES*DATA_W-1:0] rdata_q;
   logic [CNT_W-1:0]        cnt_q;
   logic                    done_q;

   logic [BANKS-1:0]  b_hit;
   logic [ROW_W-1:0]  b_row  [BANKS];
   logic [LANES-1:0]  b_take [BANKS];
   logic [DATA_W-1:0] b_wsel [BANKS];
   logic [DATA_W-1:0] b_rd   [BANKS];

   logic [LANES-1:0]  served;
   logic [LANES-1:0]  pend_nx;
   logic [DATA_W-1:0] lane_rd [LANES];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      scp_bank_pick #(
         .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
         .BANK_W(BANK_W), .BANK_ID(b)
      ) u_pick (
         .pend(pend), .addr_flat(addr_q), .wdata_flat(wdata_q),
         .hit(b_hit[b]), .row(b_row[b]), .take(b_take[b]), .wsel(b_wsel[b])
      );
      scp_bank_ram #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_ram (
         .clk(clk), .rst_n(rst_n),
         .we(state == ST_SERVE && wr_q && b_hit[b]),
         .row(b_row[b]), .wdata(b_wsel[b]), .rdata(b_rd[b])
      );
   end

   always_comb begin
      served = '0;
      for (int b = 0; b < BANKS; b++) served = served | b_take[b];
   end
   assign pend_nx = pend & ~served;

   always_comb begin
      for (int l = 0; l < LANES; l++) lane_rd[l] = b_rd[addr_q[l*ADDR_W +: BANK_W]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pend    <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state   <= ST_SERVE;
                  pend    <= req_mask;
                  wr_q    <= req_write;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  rdata_q <= '0;
                  cnt_q   <= '0;
               end
            end
            ST_SERVE: begin
               pend <= pend_nx;
               if (served != '0) cnt_q <= cnt_q + CNT_W'(1);
               for (int l = 0; l < LANES; l++) begin
                  if (served[l] && !wr_q) rdata_q[l*DATA_W +: DATA_W] <= lane_rd[l];
               end
               if (pend_nx == '0) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state == ST_SERVE);
   assign done      = done_q;
   assign rd_data   = rdata_q;
   assign rd_cycles = cnt_q;

   // every serving cycle with work left must retire at least one lane
   assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pend != '0) |-> (served != '0)) else $error("no lane served");
   assert_cycles_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_cycles <= CNT_W'(LANES))) else $error("cycle count too large");
   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && served != '0) |=> (rd_cycles == $past(rd_cycles) + CNT_W'(1)))
      else $error("cycle count did not advance");
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy) else $error("done while busy");
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle");
   assert_busy_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid)) else $error("busy without request");
endmodule

// File: tb/scp_conflict_serializer_bench.sv
module scp_conflict_serializer_bench;
   localparam int TL = 32;
   localparam int TB = 32;
   localparam int TA = 10;
   localparam int TD = 32;
   localparam int CW = $clog2(TL + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [TL-1:0]     req_mask = '0;
   logic [TL*TA-1:0]  req_addr = '0;
   logic [TL*TD-1:0]  req_wdata = '0;
   logic              busy, done;
   logic [TL*TD-1:0]  rd_data;
   logic [CW-1:0]     rd_cycles;

   int total = 0;
   int bad   = 0;

   logic [TD-1:0] model_mem [1 << TA];
   int            t_addr [TL];
   logic [TD-1:0] t_data [TL];

   scp_conflict_serializer #(.LANES(TL), .BANKS(TB), .ADDR_W(TA), .DATA_W(TD)) u_scp_conflict_serializer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .rd_cycles(rd_cycles)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one access: model computes cycles, per-lane data and memory update, then checks every cycle
   task automatic do_req(input bit wr, input logic [TL-1:0] mask, input bit poke, input string req);
      int            cyc = 0;
      int            lat;
      logic [TD-1:0] exp_rd [TL];
      for (int b = 0; b < TB; b++) begin
         int n = 0;
         for (int l = 0; l < TL; l++) begin
            bit first = 1'b1;
            if (!mask[l] || (t_addr[l] % TB) != b) continue;
            for (int k = 0; k < l; k++)
               if (mask[k] && t_addr[k] == t_addr[l]) first = 1'b0;
            if (first) n++;
         end
         if (n > cyc) cyc = n;
      end
      for (int l = 0; l < TL; l++)
         exp_rd[l] = (!wr && mask[l]) ? model_mem[t_addr[l]] : '0;
      if (wr)
         for (int l = 0; l < TL; l++) if (mask[l]) model_mem[t_addr[l]] = t_data[l];
      lat = (cyc == 0) ? 1 : cyc;

      @(negedge clk);
      chk("R7", "done idle before request", {63'd0, done}, 64'd0);
      req_valid = 1'b1;
      req_write = wr;
      req_mask  = mask;
      for (int l = 0; l < TL; l++) begin
         req_addr[l*TA +: TA]  = TA'(t_addr[l]);
         req_wdata[l*TD +: TD] = t_data[l];
      end
      for (int k = 1; k <= lat; k++) begin
         @(negedge clk);
         if (k == 1) begin
            req_valid = poke;
            if (poke) begin
               req_write = 1'b1;
               req_mask  = '1;
               for (int l = 0; l < TL; l++) begin
                  req_addr[l*TA +: TA]  = TA'(5);
                  req_wdata[l*TD +: TD] = 32'hBAD0_BAD0;
               end
            end
         end
         chk("R6", "busy during serve", {62'd0, busy, done}, 64'd2);
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7", "done pulse", {62'd0, busy, done}, 64'd1);
      chk(req, "cycle count", 64'(rd_cycles), 64'(cyc));
      for (int l = 0; l < TL; l++)
         chk(req, $sformatf("lane %0d data", l), 64'(rd_data[l*TD +: TD]), 64'(exp_rd[l]));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int a = 0; a < (1 << TA); a++) model_mem[a] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", "reset busy/done", {62'd0, busy, done}, 64'd0);
      chk("R9", "reset cycles", 64'(rd_cycles), 64'd0);
      rst_n = 1'b1;

      // R9: memory cleared, R2: unit stride loads
      for (int l = 0; l < TL; l++) begin t_addr[l] = l + 64; t_data[l] = '0; end
      do_req(1'b0, '1, 1'b0, "R9");
      // R1/R2: unit stride store then load
      for (int l = 0; l < TL; l++) begin t_addr[l] = l + 96; t_data[l] = 32'hC100_0000 | l; end
      do_req(1'b1, '1, 1'b0, "R2");
      do_req(1'b0, '1, 1'b0, "R1");
      // R3: stride 32 lands every lane in bank 0 on separate rows
      for (int l = 0; l < TL; l++) begin t_addr[l] = l * 32; t_data[l] = 32'h3200_0000 | l; end
      do_req(1'b1, '1, 1'b0, "R3");
      do_req(1'b0, '1, 1'b0, "R3");
      // R3: padded stride 33 spreads over all banks
      for (int l = 0; l < TL; l++) begin t_addr[l] = l * 33; t_data[l] = 32'h3300_0000 | l; end
      do_req(1'b1, '1, 1'b0, "R3");
      do_req(1'b0, '1, 1'b0, "R3");
      // R5: all lanes store one address, highest lane wins; R4: broadcast load
      for (int l = 0; l < TL; l++) begin t_addr[l] = 77; t_data[l] = 32'h5500_0000 | l; end
      do_req(1'b1, '1, 1'b0, "R5");
      do_req(1'b0, '1, 1'b0, "R4");
      // R8: partial mask and empty mask
      for (int l = 0; l < TL; l++) begin t_addr[l] = (l % 4) * 32 + 96; t_data[l] = '0; end
      do_req(1'b0, 32'h0F0F_00F1, 1'b0, "R8");
      do_req(1'b0, '0, 1'b0, "R8");
      // R6: request held high during busy must not store
      for (int l = 0; l < TL; l++) begin t_addr[l] = l * 32 + 1; t_data[l] = '0; end
      do_req(1'b0, '1, 1'b1, "R6");
      for (int l = 0; l < TL; l++) begin t_addr[l] = 5; t_data[l] = '0; end
      do_req(1'b0, '1, 1'b0, "R6");
      // mixed random accesses inside a 64-word window
      for (int n = 0; n < 24; n++) begin
         for (int l = 0; l < TL; l++) begin
            t_addr[l] = $urandom_range(0, 63);
            t_data[l] = $urandom;
         end
         do_req(n[0], $urandom, 1'b0, n[0] ? "R5" : "R3");
      end
      @(negedge clk);
      chk("R7", "done after last", {63'd0, done}, 64'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule